// File: doc/BRIEF.md
# Expander-Driven Display Mux Port Selector

This block steers a display-data-channel multiplexer whose control pins hang off an I2C port expander. A host issues one select command that carries the expander's 7-bit device address, a mask of the expander pins that drive the multiplexer, and the level those pins should take. The block then works through a fixed script of byte transactions. First it reads the expander's pin-direction register, clears the masked bits so those pins become outputs, and writes the value back. Then it reads the output-level register, replaces the masked bits with the requested state, and writes that value back.

The bit-level I2C engine is not part of this block. The block talks to it through a level request with a single-cycle completion pulse. Each request names one transaction kind: a one-byte write, a one-byte read, or a two-byte write. When the command says that routing is not valid, or that no router bus exists, the block finishes at once and starts no transaction. If the far side does not acknowledge a transaction, the block records the failure. It still runs the rest of the script.

Top module: `ddc_mux_port_sel`

## Requirements
- R1: After reset, busy, done, err and txn_req are all 0.
- R2: If a command is accepted with cmd_route_ok=0 or cmd_bus_ok=0, done goes high in the cycle right after the accepting edge and no transaction is requested.
- R3: A command accepted with both cmd_route_ok and cmd_bus_ok at 1 issues exactly six transactions, all to cmd_dev_addr, in this order: one-byte write of index 0x03 (txn_op=0), one-byte read (txn_op=1), two-byte write to index 0x03 (txn_op=2), one-byte write of index 0x01, one-byte read, two-byte write to index 0x01. txn_byte0 carries the index and txn_byte1 carries the value.
- R4: The value written to index 0x03 is the byte read from 0x03 with every bit set in cmd_pin_mask cleared.
- R5: The value written to index 0x01 is (read & ~mask) | (state & mask). Bits of cmd_pin_state outside the mask have no effect, and unmasked bits return unchanged.
- R6: done is high for exactly one cycle. That cycle follows at once the edge where the final write completes.
- R7: busy is high from the accepting edge until done ends. A cmd_valid seen while busy is ignored and changes no transaction.
- R8: A completion with txn_nack=1 sets err. err stays set until the next command is accepted, which clears it. The script still issues all six transactions.
- R9: The captured read byte is cleared when a command is accepted. A read that completes with txn_nack=1 leaves the captured byte unchanged.
- R10: While txn_req is high and txn_done is low, txn_req and all request fields hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Select command strobe, taken only when idle |
| cmd_route_ok | input | 1 | Routing for this connector is valid |
| cmd_bus_ok | input | 1 | A router bus is present |
| cmd_dev_addr | input | 7 | Expander device address |
| cmd_pin_mask | input | 8 | Expander pins that control the mux |
| cmd_pin_state | input | 8 | Requested levels for the masked pins |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky no-acknowledge flag of the current command |
| txn_req | output | 1 | Transaction request, held until completion |
| txn_op | output | 2 | 0 one-byte write, 1 one-byte read, 2 two-byte write |
| txn_dev_addr | output | 7 | Device address of the transaction |
| txn_byte0 | output | 8 | First written byte (register index) |
| txn_byte1 | output | 8 | Second written byte (register value) |
| txn_done | input | 1 | One-cycle completion of the current request |
| txn_nack | input | 1 | Completion was not acknowledged |
| txn_rdata | input | 8 | Byte returned by a read, valid with txn_done |

## Verification
The assertions assume that txn_done pulses for a single cycle and only while txn_req is high. They also assume that txn_nack and txn_rdata matter only in that cycle. The bench's transaction model keeps to this. It waits a fixed latency after it sees a request and raises completion for one cycle. It then lowers completion before it looks at the next request. The model keeps an expander register file, so it checks the read-modify-write results against its own stored bytes, and it injects no-acknowledge at chosen transaction positions.

// File: rtl/msel_pkg.sv
package msel_pkg;
  localparam int unsigned DEV_W  = 7;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OP_W   = 2;

  localparam logic [OP_W-1:0] OP_WR_ONE = 2'd0;
  localparam logic [OP_W-1:0] OP_RD_ONE = 2'd1;
  localparam logic [OP_W-1:0] OP_WR_TWO = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WR_DIR, S_RD_LVL, S_WR_LVL, S_DONE
  } seq_state_t;

  // Pins in the mask become outputs: their direction bits are cleared.
  function automatic logic [BYTE_W-1:0] dir_merge(input logic [BYTE_W-1:0] rd,
                                                  input logic [BYTE_W-1:0] m);
    return rd & ~m;
  endfunction

  // Masked pins take the requested level; the others keep what was read.
  function automatic logic [BYTE_W-1:0] lvl_merge(input logic [BYTE_W-1:0] rd,
                                                  input logic [BYTE_W-1:0] m,
                                                  input logic [BYTE_W-1:0] s);
    return (rd & ~m) | (s & m);
  endfunction
endpackage

// File: rtl/msel_fsm.sv
module msel_fsm
  import msel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       go_ok,
  input  logic       txn_done,
  output seq_state_t state,
  output logic       phase,
  output logic       accept,
  output logic       final_ack,
  output logic       busy,
  output logic       done
);
  seq_state_t state_n;
  logic       phase_n;

  assign accept    = (state == S_IDLE) && cmd_valid;
  assign final_ack = (state == S_WR_LVL) && txn_done;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);

  always_comb begin
    state_n = state;
    phase_n = phase;
    case (state)
      S_IDLE:   if (cmd_valid) state_n = go_ok ? S_RD_DIR : S_DONE;
      S_RD_DIR: if (txn_done) begin
                  if (phase) begin state_n = S_WR_DIR; phase_n = 1'b0; end
                  else phase_n = 1'b1;
                end
      S_WR_DIR: if (txn_done) state_n = S_RD_LVL;
      S_RD_LVL: if (txn_done) begin
                  if (phase) begin state_n = S_WR_LVL; phase_n = 1'b0; end
                  else phase_n = 1'b1;
                end
      S_WR_LVL: if (txn_done) state_n = S_DONE;
      S_DONE:   state_n = S_IDLE;
      default:  begin state_n = S_IDLE; phase_n = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      phase <= 1'b0;
    end else begin
      state <= state_n;
      phase <= phase_n;
    end
  end

  // R6: completion pulse is a single cycle and follows the final ack
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    final_ack |=> done);
  // R2: refused routing finishes on the next cycle
  a_r2_bypass_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !go_ok) |=> done);
endmodule

// File: rtl/msel_datapath.sv
module msel_datapath
  import msel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              busy,
  input  logic              rd_ack,
  input  logic              txn_done,
  input  logic              txn_nack,
  input  logic [BYTE_W-1:0] txn_rdata,
  input  logic [DEV_W-1:0]  cmd_dev_addr,
  input  logic [BYTE_W-1:0] cmd_pin_mask,
  input  logic [BYTE_W-1:0] cmd_pin_state,
  output logic [DEV_W-1:0]  dev_q,
  output logic [BYTE_W-1:0] mask_q,
  output logic [BYTE_W-1:0] lvl_q,
  output logic [BYTE_W-1:0] rd_q,
  output logic              err_q
);
  logic nack_evt;
  assign nack_evt = txn_done && txn_nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      dev_q  <= cmd_dev_addr;
      mask_q <= cmd_pin_mask;
      lvl_q  <= cmd_pin_state;
      rd_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      if (rd_ack && !txn_nack) rd_q <= txn_rdata;
      if (nack_evt) err_q <= 1'b1;
    end
  end

  // R8: error flag is sticky until a new command is taken
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !accept) |=> err_q);
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> err_q);
  // R9: a refused read leaves the captured byte alone
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_evt && !accept) |=> $stable(rd_q));
  // R7: command fields stay put while busy
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dev_q) && $stable(mask_q) && $stable(lvl_q)));
endmodule

// File: rtl/msel_req_gen.sv
module msel_req_gen
  import msel_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DIR_IDX = 8'h03,
  parameter logic [BYTE_W-1:0] LVL_IDX = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state,
  input  logic              phase,
  input  logic [DEV_W-1:0]  dev_q,
  input  logic [BYTE_W-1:0] mask_q,
  input  logic [BYTE_W-1:0] lvl_q,
  input  logic [BYTE_W-1:0] rd_q,
  output logic              txn_req,
  output logic [OP_W-1:0]   txn_op,
  output logic [DEV_W-1:0]  txn_dev_addr,
  output logic [BYTE_W-1:0] txn_byte0,
  output logic [BYTE_W-1:0] txn_byte1,
  output logic              rd_phase
);
  assign txn_dev_addr = dev_q;

  always_comb begin
    txn_req   = 1'b0;
    txn_op    = OP_WR_ONE;
    txn_byte0 = '0;
    txn_byte1 = '0;
    rd_phase  = 1'b0;
    case (state)
      S_RD_DIR: begin
        txn_req   = 1'b1;
        txn_op    = phase ? OP_RD_ONE : OP_WR_ONE;
        txn_byte0 = DIR_IDX;
        rd_phase  = phase;
      end
      S_WR_DIR: begin
        txn_req   = 1'b1;
        txn_op    = OP_WR_TWO;
        txn_byte0 = DIR_IDX;
        txn_byte1 = dir_merge(rd_q, mask_q);
      end
      S_RD_LVL: begin
        txn_req   = 1'b1;
        txn_op    = phase ? OP_RD_ONE : OP_WR_ONE;
        txn_byte0 = LVL_IDX;
        rd_phase  = phase;
      end
      S_WR_LVL: begin
        txn_req   = 1'b1;
        txn_op    = OP_WR_TWO;
        txn_byte0 = LVL_IDX;
        txn_byte1 = lvl_merge(rd_q, mask_q, lvl_q);
      end
      default: ;
    endcase
  end

  // R5: no bit outside the mask differs from what was read
  a_r5_outside_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_op == OP_WR_TWO) |-> (((txn_byte1 ^ rd_q) & ~mask_q) == '0));
  // R4: direction write leaves every masked pin as output
  a_r4_dir_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && txn_op == OP_WR_TWO && txn_byte0 == DIR_IDX) |-> ((txn_byte1 & mask_q) == '0));
endmodule

// File: rtl/ddc_mux_port_sel.sv
module ddc_mux_port_sel
  import msel_pkg::*;
#(
  parameter logic [7:0] DIR_IDX = 8'h03,
  parameter logic [7:0] LVL_IDX = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_route_ok,
  input  logic       cmd_bus_ok,
  input  logic [6:0] cmd_dev_addr,
  input  logic [7:0] cmd_pin_mask,
  input  logic [7:0] cmd_pin_state,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       txn_req,
  output logic [1:0] txn_op,
  output logic [6:0] txn_dev_addr,
  output logic [7:0] txn_byte0,
  output logic [7:0] txn_byte1,
  input  logic       txn_done,
  input  logic       txn_nack,
  input  logic [7:0] txn_rdata
);
  seq_state_t        state;
  logic              phase, accept, final_ack, rd_phase, rd_ack, go_ok;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] mask_q, lvl_q, rd_q;

  assign go_ok  = cmd_route_ok && cmd_bus_ok;
  assign rd_ack = rd_phase && txn_done;

  msel_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .go_ok(go_ok),
    .txn_done(txn_done), .state(state), .phase(phase), .accept(accept),
    .final_ack(final_ack), .busy(busy), .done(done)
  );

  msel_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .rd_ack(rd_ack),
    .txn_done(txn_done), .txn_nack(txn_nack), .txn_rdata(txn_rdata),
    .cmd_dev_addr(cmd_dev_addr), .cmd_pin_mask(cmd_pin_mask),
    .cmd_pin_state(cmd_pin_state), .dev_q(dev_q), .mask_q(mask_q),
    .lvl_q(lvl_q), .rd_q(rd_q), .err_q(err)
  );

  msel_req_gen #(.DIR_IDX(DIR_IDX), .LVL_IDX(LVL_IDX)) u_req (
    .clk(clk), .rst_n(rst_n), .state(state), .phase(phase), .dev_q(dev_q),
    .mask_q(mask_q), .lvl_q(lvl_q), .rd_q(rd_q), .txn_req(txn_req),
    .txn_op(txn_op), .txn_dev_addr(txn_dev_addr), .txn_byte0(txn_byte0),
    .txn_byte1(txn_byte1), .rd_phase(rd_phase)
  );

  // R10: an outstanding request holds every field until completion
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !txn_done) |=> (txn_req && $stable(txn_op) && $stable(txn_byte0)
                                && $stable(txn_byte1) && $stable(txn_dev_addr)));
  // R2: a refused command raises no request
  a_r2_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !go_ok) |=> !txn_req);
  // R1/R7: no request outside a busy command
  a_r7_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> busy);
endmodule

// File: tb/tb_ddc_mux_port_sel.sv
module tb_ddc_mux_port_sel;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_route_ok = 1'b0, cmd_bus_ok = 1'b0;
  logic [6:0] cmd_dev_addr = '0;
  logic [7:0] cmd_pin_mask = '0, cmd_pin_state = '0;
  logic       busy, done, err, txn_req;
  logic [1:0] txn_op;
  logic [6:0] txn_dev_addr;
  logic [7:0] txn_byte0, txn_byte1;
  logic       txn_done = 1'b0, txn_nack = 1'b0;
  logic [7:0] txn_rdata = '0;

  int errors = 0, checks = 0;
  int cyc = 0;
  int done_cnt = 0, done_cyc = -1, last_cyc = -1;
  int nack_at = -1;
  int n_log = 0, hold_bad = 0, wait_cnt = 0;
  logic [1:0] lg_op [0:15];
  logic [6:0] lg_dev [0:15];
  logic [7:0] lg_b0 [0:15];
  logic [7:0] lg_b1 [0:15];
  logic [7:0] exp_reg [0:7];
  logic [7:0] cur_idx = '0;
  logic [1:0] f_op; logic [7:0] f_b0, f_b1;

  ddc_mux_port_sel dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk); #2;
    if (done) begin done_cnt++; done_cyc = cyc; end
  end

  // transaction model with an expander register file
  initial begin
    forever begin
      @(negedge clk);
      if (txn_done) begin
        txn_done = 1'b0; txn_nack = 1'b0;
      end else if (txn_req) begin
        if (wait_cnt == 0) begin f_op = txn_op; f_b0 = txn_byte0; f_b1 = txn_byte1; end
        if (wait_cnt == 2) begin
          if (f_op != txn_op || f_b0 != txn_byte0 || f_b1 != txn_byte1) hold_bad++;
          if (n_log < 16) begin
            lg_op[n_log] = txn_op; lg_dev[n_log] = txn_dev_addr;
            lg_b0[n_log] = txn_byte0; lg_b1[n_log] = txn_byte1;
          end
          txn_nack = (n_log == nack_at);
          txn_rdata = 8'hEE;
          if (!txn_nack) begin
            case (txn_op)
              2'd0: cur_idx = txn_byte0;
              2'd1: txn_rdata = exp_reg[cur_idx[2:0]];
              2'd2: exp_reg[txn_byte0[2:0]] = txn_byte1;
              default: ;
            endcase
          end
          n_log++;
          last_cyc = cyc;
          txn_done = 1'b1;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] want_dir(logic [7:0] r, logic [7:0] m);
    logic [7:0] v = r;
    for (int i = 0; i < 8; i++) if (m[i]) v[i] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] want_lvl(logic [7:0] r, logic [7:0] m, logic [7:0] s);
    logic [7:0] v = r;
    for (int i = 0; i < 8; i++) if (m[i]) v[i] = s[i];
    return v;
  endfunction

  // issue one command and wait for its completion pulse
  task automatic run_cmd(input logic [6:0] a, input logic [7:0] m, input logic [7:0] s,
                         input bit rok, input bit bok, input int nk,
                         input bit poke, output int cmd_cyc);
    n_log = 0; done_cnt = 0; nack_at = nk;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dev_addr = a; cmd_pin_mask = m; cmd_pin_state = s;
    cmd_route_ok = rok; cmd_bus_ok = bok; cmd_cyc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      cmd_valid = 1'b1; cmd_dev_addr = 7'h11; cmd_route_ok = 1'b1; cmd_bus_ok = 1'b1;
      @(negedge clk); cmd_valid = 1'b0;
    end
    for (int i = 0; i < 500 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R6 done pulse count", done_cnt, 1);
  endtask

  task automatic check_script(input logic [6:0] a, input logic [7:0] w3, input logic [7:0] w1,
                              input string tag);
    chk(n_log == 6, {tag, " R3 txn count"}, n_log, 6);
    for (int i = 0; i < 6; i++) begin
      logic [1:0] eo = (i % 3 == 0) ? 2'd0 : (i % 3 == 1) ? 2'd1 : 2'd2;
      logic [7:0] ei = (i < 3) ? 8'h03 : 8'h01;
      chk(lg_op[i] == eo, {tag, " R3 op order"}, lg_op[i], eo);
      chk(lg_dev[i] == a, {tag, " R3 device addr"}, lg_dev[i], a);
      if (eo != 2'd1) chk(lg_b0[i] == ei, {tag, " R3 index"}, lg_b0[i], ei);
    end
    chk(lg_b1[2] == w3, {tag, " R4 direction value"}, lg_b1[2], w3);
    chk(lg_b1[5] == w1, {tag, " R5 level value"}, lg_b1[5], w1);
    chk(done_cyc == last_cyc + 1, {tag, " R6 done timing"}, done_cyc, last_cyc + 1);
    chk(hold_bad == 0, {tag, " R10 request held"}, hold_bad, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !txn_req, "R1 reset outputs",
        {busy, done, err, txn_req}, 0);
  endtask

  task automatic t_basic();
    int cc;
    exp_reg[3] = 8'hF5; exp_reg[1] = 8'h3C;
    run_cmd(7'h4A, 8'h0C, 8'h08, 1, 1, -1, 0, cc);
    check_script(7'h4A, want_dir(8'hF5, 8'h0C), want_lvl(8'h3C, 8'h0C, 8'h08), "basic");
    chk(exp_reg[1] == 8'h38, "R5 expander level reg", exp_reg[1], 8'h38);
    chk(err == 1'b0, "R8 no error", err, 0);
    chk(!busy, "R7 idle after", busy, 0);
  endtask

  task automatic t_outside_mask();
    int cc;
    exp_reg[3] = 8'h81; exp_reg[1] = 8'h00;
    run_cmd(7'h20, 8'h81, 8'hFF, 1, 1, -1, 0, cc);
    check_script(7'h20, 8'h00, 8'h81, "mask");
    exp_reg[3] = 8'h5A; exp_reg[1] = 8'hA5;
    run_cmd(7'h7F, 8'h00, 8'hFF, 1, 1, -1, 0, cc);
    check_script(7'h7F, 8'h5A, 8'hA5, "nomask R5");
  endtask

  task automatic t_bypass();
    int cc;
    run_cmd(7'h30, 8'hFF, 8'hFF, 0, 1, -1, 0, cc);
    chk(n_log == 0, "R2 route invalid no traffic", n_log, 0);
    chk(done_cyc == cc + 1, "R2 route invalid done timing", done_cyc, cc + 1);
    run_cmd(7'h30, 8'hFF, 8'hFF, 1, 0, -1, 0, cc);
    chk(n_log == 0, "R2 no bus no traffic", n_log, 0);
    chk(done_cyc == cc + 1, "R2 no bus done timing", done_cyc, cc + 1);
  endtask

  task automatic t_busy_ignore();
    int cc;
    exp_reg[3] = 8'hFF; exp_reg[1] = 8'h0F;
    run_cmd(7'h52, 8'h30, 8'h10, 1, 1, -1, 1, cc);
    check_script(7'h52, 8'hCF, 8'h1F, "R7 busy poke");
  endtask

  task automatic t_nack();
    int cc;
    exp_reg[3] = 8'hFF; exp_reg[1] = 8'h77;
    run_cmd(7'h44, 8'h03, 8'h02, 1, 1, 1, 0, cc);
    check_script(7'h44, 8'h00, want_lvl(8'h77, 8'h03, 8'h02), "R9 nacked read");
    chk(err == 1'b1, "R8 err set", err, 1);
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R8 err sticky", err, 1);
    exp_reg[3] = 8'hF0; exp_reg[1] = 8'h00;
    run_cmd(7'h44, 8'h10, 8'h10, 1, 1, 5, 0, cc);
    chk(n_log == 6, "R8 sequence continues after nack", n_log, 6);
    chk(err == 1'b1, "R8 err on final write nack", err, 1);
    run_cmd(7'h44, 8'h10, 8'h10, 1, 1, -1, 0, cc);
    chk(err == 1'b0, "R8 err cleared by new command", err, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_reg[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_outside_mask();
    t_bypass();
    t_busy_ignore();
    t_nack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule